// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and decides which interrupt, if any, is offered to it. It holds four pieces of state: the processor's current priority threshold, the priority requested for an inter-processor interrupt, the number of the pending source, and that source's priority. A numerically lower priority is more favored, and a pending priority of 0xFF means that nothing is pending. The inter-processor interrupt is handled inside the presenter as a pseudo-source whose reserved number is 2. Source number 0 means that no source is pending.

The processor issues four commands: accept, set threshold, set inter-processor request, and end-of-interrupt. The source controller delivers source and priority pairs to the presenter. The presenter answers on the source side with reject, refusal ("bounce"), resend and end-of-interrupt notifications. All notifications, and the accept response, are registered and appear one cycle after the command. The interrupt line and the state outputs follow the registered state.

Top module: `irq_presenter`

## Requirements
- R1: Reset state.
  - Threshold is 0x00.
  - Inter-processor request is 0xFF.
  - Pending source is 0 and pending priority is 0xFF.
  - The interrupt line is low and no notification is raised.
- R2: The interrupt line is high exactly when the pending source is nonzero and the pending priority is strictly below the threshold.
- R3: Accept command (cmd_op=0).
  - The response word is the threshold in bits 31:24 and the pending source in bits 23:0.
  - If a source was pending, the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source becomes 0.
  - Otherwise the state is unchanged.
- R4: Set inter-processor request (cmd_op=2, value in cmd_data[7:0]).
  - The request is stored.
  - If the value is below the threshold and not above the pending priority, the pending source is rejected, source 2 becomes pending and the pending priority takes the value.
- R5: When the inter-processor request is set to a numerically larger value than before, a stored need-resend flag is cleared. If that flag was set, a resend request is raised.
- R6: Set threshold (cmd_op=1, value in cmd_data[7:0]).
  - An equal value changes nothing.
  - A larger value takes the lowering path: the threshold is loaded, and source 2 becomes pending at the request priority if the request is below the new threshold and not above the pending priority. The need-resend flag is cleared, and a resend is raised if it was set.
- R7: A smaller threshold value is stored. If it is not above the pending priority, the pending source is rejected, the pending source becomes 0 and the pending priority becomes 0xFF.
- R8: End-of-interrupt (cmd_op=3).
  - It takes the lowering path with cmd_data[31:24] as the new threshold.
  - For source cmd_data[23:0], other than 0 or 2, it raises an end-of-interrupt notification. If eoi_src_level is high, it also rejects that source.
- R9: A reject of source 0 or source 2 is never reported on the reject port.
- R10: A delivery in a cycle without a command is accepted when its priority is below both the threshold and the pending priority. The previous pending source is then rejected and replaced.
- R11: A delivery that is not accepted is bounced back with its source number in the next cycle and sets the need-resend flag.
- R12: A delivery arriving in the same cycle as a command is always bounced, after the command has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 accept, 1 set threshold, 2 set inter-processor request, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| eoi_src_level | input | 1 | Level of the source named in an end-of-interrupt |
| dlv_valid | input | 1 | Delivery strobe from the source side |
| dlv_src | input | 24 | Delivered source number |
| dlv_pri | input | 8 | Delivered priority |
| irq_o | output | 1 | Interrupt line to the processor |
| cppr_o | output | 8 | Current threshold |
| mfrr_o | output | 8 | Inter-processor request priority |
| xisr_o | output | 24 | Pending source number |
| pend_o | output | 8 | Pending priority |
| rsp_valid | output | 1 | Accept response valid |
| rsp_data | output | 32 | Accept response word |
| rej_valid | output | 1 | Reject notification |
| rej_src | output | 24 | Rejected source |
| resend_o | output | 1 | Resend request to the source side |
| eoi_valid | output | 1 | End-of-interrupt notification |
| eoi_src | output | 24 | Source being ended |
| bnc_valid | output | 1 | Delivery refused |
| bnc_src | output | 24 | Refused source |

## Verification
A processor command and a source delivery can arrive in the same cycle. The block applies the command first and then bounces the delivery. The bounce sets the need-resend flag after the command has cleared it, so a later lowering of the threshold must raise a resend. The bench forces this collision in a directed step and then draws both strobes independently on most random cycles. Every cycle it compares the refusal, the reject and the resend outputs against a reference model that applies the same ordering.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int SRC_W = 24;
    localparam int PRI_W = 8;
    localparam int WORD_W = SRC_W + PRI_W;
    localparam logic [SRC_W-1:0] IPI_SRC = SRC_W'(2);
    localparam logic [PRI_W-1:0] PRI_NONE = '1;

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_SET_CPPR = 2'd1,
        OP_SET_MFRR = 2'd2,
        OP_EOI      = 2'd3
    } irqp_op_e;

    typedef struct packed {
        logic [PRI_W-1:0] cppr;
        logic [PRI_W-1:0] mfrr;
        logic [PRI_W-1:0] pend;
        logic [SRC_W-1:0] xisr;
        logic             need_resend;
    } irqp_state_t;

    typedef struct packed {
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_data;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              resend;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              bnc_v;
        logic [SRC_W-1:0]  bnc_src;
    } irqp_event_t;
endpackage

// File: rtl/irqp_cmd.sv
module irqp_cmd
    import irqp_pkg::*;
(
    input  irqp_state_t              st_i,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [WORD_W-1:0]        cmd_data,
    input  logic                     src_level,
    output irqp_state_t              st_o,
    output logic                     rsp_v,
    output logic [WORD_W-1:0]        rsp_data,
    output logic                     rej_v,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     resend,
    output logic                     eoi_v,
    output logic [SRC_W-1:0]         eoi_src
);
    logic [PRI_W-1:0] val;
    logic [PRI_W-1:0] top_pri;
    logic [SRC_W-1:0] op_src;
    logic [SRC_W-1:0] raw_rej;
    logic             lower_en;
    logic [PRI_W-1:0] lower_to;

    assign val     = cmd_data[PRI_W-1:0];
    assign top_pri = cmd_data[WORD_W-1:SRC_W];
    assign op_src  = cmd_data[SRC_W-1:0];

    always_comb begin
        st_o     = st_i;
        rsp_v    = 1'b0;
        rsp_data = '0;
        raw_rej  = '0;
        resend   = 1'b0;
        eoi_v    = 1'b0;
        eoi_src  = '0;
        lower_en = 1'b0;
        lower_to = '0;
        if (cmd_valid) begin
            unique case (irqp_op_e'(cmd_op))
                OP_ACCEPT: begin
                    rsp_v    = 1'b1;
                    rsp_data = {st_i.cppr, st_i.xisr};
                    if (st_i.xisr != '0) begin
                        st_o.cppr = st_i.pend;
                        st_o.pend = PRI_NONE;
                        st_o.xisr = '0;
                    end
                end
                OP_SET_CPPR: begin
                    if (val > st_i.cppr) begin
                        lower_en = 1'b1;
                        lower_to = val;
                    end else if (val < st_i.cppr) begin
                        st_o.cppr = val;
                        if (val <= st_i.pend) begin
                            raw_rej   = st_i.xisr;
                            st_o.xisr = '0;
                            st_o.pend = PRI_NONE;
                        end
                    end
                end
                OP_SET_MFRR: begin
                    st_o.mfrr = val;
                    if (val < st_i.cppr && val <= st_i.pend) begin
                        raw_rej   = st_i.xisr;
                        st_o.pend = val;
                        st_o.xisr = IPI_SRC;
                    end
                    if (val > st_i.mfrr) begin
                        resend           = st_i.need_resend;
                        st_o.need_resend = 1'b0;
                    end
                end
                OP_EOI: begin
                    lower_en = 1'b1;
                    lower_to = top_pri;
                    if (op_src != IPI_SRC && op_src != '0) begin
                        eoi_v   = 1'b1;
                        eoi_src = op_src;
                        if (src_level) raw_rej = op_src;
                    end
                end
                default: ;
            endcase
        end
        if (lower_en) begin
            st_o.cppr = lower_to;
            if (st_i.mfrr < lower_to && st_i.mfrr <= st_i.pend) begin
                st_o.pend = st_i.mfrr;
                st_o.xisr = IPI_SRC;
            end
            resend           = st_i.need_resend;
            st_o.need_resend = 1'b0;
        end
    end

    assign rej_v   = (raw_rej != '0) && (raw_rej != IPI_SRC);
    assign rej_src = rej_v ? raw_rej : '0;
endmodule

// File: rtl/irqp_dlv.sv
module irqp_dlv
    import irqp_pkg::*;
(
    input  irqp_state_t       st_i,
    input  logic              dlv_valid,
    input  logic              blocked,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRI_W-1:0]  dlv_pri,
    output irqp_state_t       st_o,
    output logic              disp_v,
    output logic [SRC_W-1:0]  disp_src,
    output logic              bnc_v,
    output logic [SRC_W-1:0]  bnc_src
);
    logic take;

    assign take = dlv_valid && !blocked &&
                  dlv_pri < st_i.cppr && dlv_pri < st_i.pend;

    always_comb begin
        st_o     = st_i;
        disp_v   = 1'b0;
        disp_src = '0;
        bnc_v    = 1'b0;
        bnc_src  = '0;
        if (take) begin
            st_o.xisr = dlv_src;
            st_o.pend = dlv_pri;
            if (st_i.xisr != '0 && st_i.xisr != IPI_SRC) begin
                disp_v   = 1'b1;
                disp_src = st_i.xisr;
            end
        end else if (dlv_valid) begin
            bnc_v            = 1'b1;
            bnc_src          = dlv_src;
            st_o.need_resend = 1'b1;
        end
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              eoi_src_level,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRI_W-1:0]  dlv_pri,
    output logic              irq_o,
    output logic [PRI_W-1:0]  cppr_o,
    output logic [PRI_W-1:0]  mfrr_o,
    output logic [SRC_W-1:0]  xisr_o,
    output logic [PRI_W-1:0]  pend_o,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_o,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              bnc_valid,
    output logic [SRC_W-1:0]  bnc_src
);
    irqp_state_t st_q, st_d, st_cmd, st_dlv;
    irqp_event_t ev_q, ev_d;

    logic              c_rsp_v, c_rej_v, c_resend, c_eoi_v;
    logic [WORD_W-1:0] c_rsp_data;
    logic [SRC_W-1:0]  c_rej_src, c_eoi_src;
    logic              d_disp_v, d_bnc_v;
    logic [SRC_W-1:0]  d_disp_src, d_bnc_src;

    irqp_cmd u_cmd (
        .st_i     (st_q),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .src_level(eoi_src_level),
        .st_o     (st_cmd),
        .rsp_v    (c_rsp_v),
        .rsp_data (c_rsp_data),
        .rej_v    (c_rej_v),
        .rej_src  (c_rej_src),
        .resend   (c_resend),
        .eoi_v    (c_eoi_v),
        .eoi_src  (c_eoi_src)
    );

    // Delivery is judged against the post-command state; a command blocks it.
    irqp_dlv u_dlv (
        .st_i     (st_cmd),
        .dlv_valid(dlv_valid),
        .blocked  (cmd_valid),
        .dlv_src  (dlv_src),
        .dlv_pri  (dlv_pri),
        .st_o     (st_dlv),
        .disp_v   (d_disp_v),
        .disp_src (d_disp_src),
        .bnc_v    (d_bnc_v),
        .bnc_src  (d_bnc_src)
    );

    always_comb begin
        st_d          = st_dlv;
        ev_d.rsp_v    = c_rsp_v;
        ev_d.rsp_data = c_rsp_data;
        ev_d.rej_v    = c_rej_v | d_disp_v;
        ev_d.rej_src  = c_rej_v ? c_rej_src : d_disp_src;
        ev_d.resend   = c_resend;
        ev_d.eoi_v    = c_eoi_v;
        ev_d.eoi_src  = c_eoi_src;
        ev_d.bnc_v    = d_bnc_v;
        ev_d.bnc_src  = d_bnc_src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cppr        <= '0;
            st_q.mfrr        <= PRI_NONE;
            st_q.pend        <= PRI_NONE;
            st_q.xisr        <= '0;
            st_q.need_resend <= 1'b0;
            ev_q             <= '0;
        end else begin
            st_q <= st_d;
            ev_q <= ev_d;
        end
    end

    assign irq_o     = (st_q.xisr != '0) && (st_q.pend < st_q.cppr);
    assign cppr_o    = st_q.cppr;
    assign mfrr_o    = st_q.mfrr;
    assign xisr_o    = st_q.xisr;
    assign pend_o    = st_q.pend;
    assign rsp_valid = ev_q.rsp_v;
    assign rsp_data  = ev_q.rsp_data;
    assign rej_valid = ev_q.rej_v;
    assign rej_src   = ev_q.rej_src;
    assign resend_o  = ev_q.resend;
    assign eoi_valid = ev_q.eoi_v;
    assign eoi_src   = ev_q.eoi_src;
    assign bnc_valid = ev_q.bnc_v;
    assign bnc_src   = ev_q.bnc_src;

    assert_idle_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xisr_o == '0 |-> pend_o == PRI_NONE);

    assert_rsp_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd0 |=>
            rsp_valid && rsp_data == {$past(cppr_o), $past(xisr_o)});

    assert_rej_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> rej_src != IPI_SRC && rej_src != '0);

    assert_equal_cppr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd1 && cmd_data[PRI_W-1:0] == cppr_o && !dlv_valid |=>
            $stable(cppr_o) && $stable(xisr_o) && $stable(pend_o) &&
            !rej_valid && !resend_o);

    assert_collide_bounce_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && dlv_valid |=> bnc_valid && bnc_src == $past(dlv_src));

    assert_resend_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resend_o |-> $past(cmd_valid));
endmodule

// File: tb/tb_irq_presenter.sv
`timescale 1ns/1ps
module tb_irq_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        eoi_src_level = 1'b0;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_pri = '0;
    logic        irq_o, rsp_valid, rej_valid, resend_o, eoi_valid, bnc_valid;
    logic [7:0]  cppr_o, mfrr_o, pend_o;
    logic [23:0] xisr_o, rej_src, eoi_src, bnc_src;
    logic [31:0] rsp_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    irq_presenter dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .eoi_src_level(eoi_src_level), .dlv_valid(dlv_valid),
        .dlv_src(dlv_src), .dlv_pri(dlv_pri), .irq_o(irq_o), .cppr_o(cppr_o),
        .mfrr_o(mfrr_o), .xisr_o(xisr_o), .pend_o(pend_o), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rej_valid(rej_valid), .rej_src(rej_src),
        .resend_o(resend_o), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .bnc_valid(bnc_valid), .bnc_src(bnc_src)
    );

    // Reference model state and expected notifications
    logic [7:0]  m_cppr, m_mfrr, m_pend;
    logic [23:0] m_xisr;
    bit          m_need;
    bit          e_rsp_v, e_rej_v, e_rs, e_eoi_v, e_bnc_v;
    logic [31:0] e_rsp_d;
    logic [23:0] e_rej_s, e_eoi_s, e_bnc_s;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic void m_reject(input logic [23:0] s);
        if (s != 24'd0 && s != 24'd2) begin
            e_rej_v = 1'b1;
            e_rej_s = s;
        end
    endfunction

    function automatic void m_lower(input logic [7:0] c);
        m_cppr = c;
        if (m_mfrr < c && m_mfrr <= m_pend) begin
            m_pend = m_mfrr;
            m_xisr = 24'd2;
        end
        e_rs   = m_need;
        m_need = 1'b0;
    endfunction

    function automatic void m_apply(input bit cv, input logic [1:0] op,
                                    input logic [31:0] d, input bit lvl, input bit dv,
                                    input logic [23:0] s, input logic [7:0] p);
        logic [7:0] v;
        v = d[7:0];
        e_rsp_v = 0; e_rsp_d = '0; e_rej_v = 0; e_rej_s = '0; e_rs = 0;
        e_eoi_v = 0; e_eoi_s = '0; e_bnc_v = 0; e_bnc_s = '0;
        if (cv) begin
            case (op)
                2'd0: begin
                    e_rsp_v = 1; e_rsp_d = {m_cppr, m_xisr};
                    if (m_xisr != 0) begin
                        m_cppr = m_pend; m_pend = 8'hFF; m_xisr = 0;
                    end
                end
                2'd1: begin
                    if (v > m_cppr) m_lower(v);
                    else if (v < m_cppr) begin
                        m_cppr = v;
                        if (v <= m_pend) begin
                            m_reject(m_xisr); m_xisr = 0; m_pend = 8'hFF;
                        end
                    end
                end
                2'd2: begin
                    if (v < m_cppr && v <= m_pend) begin
                        m_reject(m_xisr); m_pend = v; m_xisr = 24'd2;
                    end
                    if (v > m_mfrr) begin
                        e_rs = m_need; m_need = 0;
                    end
                    m_mfrr = v;
                end
                default: begin
                    m_lower(d[31:24]);
                    if (d[23:0] != 0 && d[23:0] != 24'd2) begin
                        e_eoi_v = 1; e_eoi_s = d[23:0];
                        if (lvl) m_reject(d[23:0]);
                    end
                end
            endcase
        end
        if (dv) begin
            if (!cv && p < m_cppr && p < m_pend) begin
                m_reject(m_xisr); m_xisr = s; m_pend = p;
            end else begin
                e_bnc_v = 1; e_bnc_s = s; m_need = 1;
            end
        end
    endfunction

    task automatic step(input bit cv, input logic [1:0] op, input logic [31:0] d,
                        input bit lvl, input bit dv, input logic [23:0] s,
                        input logic [7:0] p, input string tag);
        cmd_valid = cv; cmd_op = op; cmd_data = d; eoi_src_level = lvl;
        dlv_valid = dv; dlv_src = s; dlv_pri = p;
        m_apply(cv, op, d, lvl, dv, s, p);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; dlv_valid = 0;
        chk({cppr_o, mfrr_o, pend_o} == {m_cppr, m_mfrr, m_pend}, {tag, " pri state"},
            {8'd0, cppr_o, mfrr_o, pend_o}, {8'd0, m_cppr, m_mfrr, m_pend});
        chk(xisr_o == m_xisr, {tag, " pending source"}, {8'd0, xisr_o}, {8'd0, m_xisr});
        chk(irq_o == (m_xisr != 0 && m_pend < m_cppr), "R2 irq line",
            {31'd0, irq_o}, {31'd0, (m_xisr != 0 && m_pend < m_cppr)});
        chk(rsp_valid == e_rsp_v && (!e_rsp_v || rsp_data == e_rsp_d), {tag, " R3 response"},
            rsp_data, e_rsp_d);
        chk(rej_valid == e_rej_v && (!e_rej_v || rej_src == e_rej_s), {tag, " R9 reject"},
            {rej_valid, 7'd0, rej_src}, {e_rej_v, 7'd0, e_rej_s});
        chk(resend_o == e_rs, {tag, " R5 resend"}, {31'd0, resend_o}, {31'd0, e_rs});
        chk(eoi_valid == e_eoi_v && (!e_eoi_v || eoi_src == e_eoi_s), {tag, " R8 eoi"},
            {eoi_valid, 7'd0, eoi_src}, {e_eoi_v, 7'd0, e_eoi_s});
        chk(bnc_valid == e_bnc_v && (!e_bnc_v || bnc_src == e_bnc_s), {tag, " R11 bounce"},
            {bnc_valid, 7'd0, bnc_src}, {e_bnc_v, 7'd0, e_bnc_s});
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd4242;
        void'($urandom(seed));
        m_cppr = 0; m_mfrr = 8'hFF; m_pend = 8'hFF; m_xisr = 0; m_need = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(cppr_o == 8'h00 && mfrr_o == 8'hFF && pend_o == 8'hFF && xisr_o == 0,
            "R1 reset state", {cppr_o, mfrr_o, pend_o, 8'd0}, 32'h00FFFF00);
        chk(!irq_o && !rej_valid && !resend_o && !eoi_valid && !bnc_valid && !rsp_valid,
            "R1 reset outputs", {26'd0, irq_o, rej_valid, resend_o, eoi_valid, bnc_valid,
            rsp_valid}, 32'd0);
        // Directed corner cases
        step(0, 0, 0, 0, 1, 24'd5, 8'd3, "R11 masked delivery");
        step(1, 1, 32'hFF, 0, 0, 0, 0, "R6 lower threshold");
        chk(resend_o == 1'b1, "R6 lowering resend", {31'd0, resend_o}, 32'd1);
        step(1, 1, 32'hFF, 0, 0, 0, 0, "R6 equal threshold");
        step(0, 0, 0, 0, 1, 24'd7, 8'd8, "R10 accept delivery");
        chk(irq_o == 1'b1, "R2 irq high", {31'd0, irq_o}, 32'd1);
        step(0, 0, 0, 0, 1, 24'd9, 8'd4, "R10 displacement");
        chk(rej_valid && rej_src == 24'd7, "R10 displaced reject", {8'd0, rej_src}, 32'd7);
        step(1, 2, 32'h4, 0, 0, 0, 0, "R4 request takes over");
        step(1, 2, 32'h3, 0, 0, 0, 0, "R9 ipi reject hidden");
        step(1, 0, 0, 0, 0, 0, 0, "R3 accept ipi");
        chk(rsp_data == 32'hFF000002, "R3 response word", rsp_data, 32'hFF000002);
        step(1, 3, 32'hFF000002, 0, 0, 0, 0, "R8 eoi of ipi");
        step(1, 1, 32'h10, 0, 1, 24'd11, 8'd1, "R12 collision");
        chk(bnc_valid && bnc_src == 24'd11, "R12 collision bounce", {8'd0, bnc_src}, 32'd11);
        step(1, 2, 32'h20, 0, 0, 0, 0, "R5 request raised");
        chk(resend_o == 1'b1, "R5 resend after bounce", {31'd0, resend_o}, 32'd1);
        step(1, 1, 32'h2, 0, 0, 0, 0, "R7 raise threshold");
        step(1, 1, 32'h30, 0, 0, 0, 0, "R6 lower to ipi");
        step(0, 0, 0, 0, 1, 24'd12, 8'd5, "R10 replace ipi");
        step(1, 0, 0, 0, 0, 0, 0, "R3 accept source");
        step(1, 3, 32'h3000000C, 1, 0, 0, 0, "R8 eoi asserted");
        chk(eoi_valid && rej_valid && rej_src == 24'd12, "R8 eoi reject",
            {8'd0, rej_src}, 32'd12);
        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit cv, dv, lvl;
            logic [1:0] op;
            logic [31:0] d;
            logic [7:0] p;
            logic [23:0] s;
            string tag;
            cv  = ($urandom_range(0, 99) < 60);
            dv  = ($urandom_range(0, 99) < 45);
            lvl = $urandom_range(0, 1);
            op  = 2'($urandom_range(0, 3));
            p   = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 20));
            d   = {8'($urandom_range(0, 24)), 24'($urandom_range(0, 16))};
            if (op == 2'd1 || op == 2'd2)
                d = ($urandom_range(0, 7) == 0) ? 32'hFF : 32'($urandom_range(0, 24));
            s   = 24'($urandom_range(3, 40));
            case (op)
                2'd0: tag = "R3 random";
                2'd1: tag = "R7 random";
                2'd2: tag = "R4 random";
                default: tag = "R8 random";
            endcase
            if (!cv) tag = "R10 random";
            step(cv, op, d, lvl, dv, s, p, tag);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule